// File: doc/BRIEF.md
# Multi-function pad control unit

This block sits between a set of internal peripherals and one external I/O pad. Software writes a single 32-bit configuration word over a plain register bus. The word picks which of eight peripheral output and output-enable pairs drives the pad. It also sets the pad's pull resistors and its drive-strength and slew code, and it can let fixed low-power values take over the pad while the chip is asleep.

The pad input is synchronised and watched for rising and falling edges. An edge of an enabled polarity sets a sticky flag. The flag becomes a wake request only when the external wake-enable input for this pad is high, so an edge seen on its own never wakes the system. The flag is cleared by a register write that sets the edge-clear bit, and edge detection stays off for as long as that bit is stored.

Top module: `mfpad_ctrl`

## Requirements
- R1: Register bits 3 and 31:16 always read back as zero and ignore writes; every other bit reads back the last value written. After reset the whole register reads zero.
- R2: Outside the low-power override, pad_out and pad_oe follow fn_out[k] and fn_oe[k], where k is the function number in register bits 2:0.
- R3: While low_power is high and bit 9 is set, pad_oe equals the inverse of bit 7 (bit 7 is active low) and pad_out equals bit 8.
- R4: While low_power is low or bit 9 is clear, bits 7 and 8 have no effect on pad_out or pad_oe.
- R5: With bit 15 set, pad_pu equals bit 14 and pad_pd equals bit 13. With bit 15 clear, they follow fn_pu[k] and fn_pd[k] of the selected function.
- R6: pad_drive equals register bits 12:10 unchanged. The codes are 0 to 3 for fast 1, 2, 3 and 4 mA, 4 for slow 6 mA, 5 for fast 6 mA, 6 for slow 10 mA and 7 for fast 10 mA.
- R7: With bit 4 set, a rising pad_in sets edge_flag on the third clock edge after the change, because of two synchroniser stages and one flag register. With bit 5 set, a falling pad_in does the same. The flag then stays set.
- R8: An edge whose polarity is not enabled leaves edge_flag clear.
- R9: A write with bit 6 set clears edge_flag on that clock edge. No edge sets the flag while bit 6 stays stored.
- R10: wake_req is high exactly when edge_flag and wake_en are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| fn_out | input | 8 | Output data of each alternate function |
| fn_oe | input | 8 | Output enable of each alternate function |
| fn_pu | input | 8 | Pull-up request of each alternate function |
| fn_pd | input | 8 | Pull-down request of each alternate function |
| low_power | input | 1 | System is in a low-power mode |
| wake_en | input | 1 | External wake enable for this pad |
| pad_in | input | 1 | Asynchronous level from the pad |
| pad_out | output | 1 | Data to the pad |
| pad_oe | output | 1 | Output enable to the pad |
| pad_pu | output | 1 | Pull-up enable to the pad |
| pad_pd | output | 1 | Pull-down enable to the pad |
| pad_drive | output | 3 | Drive strength and slew code |
| edge_flag | output | 1 | Sticky edge-detected status |
| wake_req | output | 1 | Wake request |

## Verification
The hardest case to reach is an edge that arrives while the edge-clear bit is stored, or in the same cycle as a clearing write. The stimulus first writes the clear bit together with both polarity enables and then toggles pad_in, which shows that suppression holds even when the polarities are enabled. Re-enabling without the clear bit then shows that the unit detects edges again. The random part varies the function vectors, the configuration word and low_power together, so the override and the pull-source selection are exercised against each other.

// File: rtl/mfpad_pkg.sv
package mfpad_pkg;
    localparam int NUM_FUNC = 8;
    localparam int SEL_W    = $clog2(NUM_FUNC);
    localparam int REG_W    = 32;
    localparam int DRV_W    = 3;
    localparam logic [REG_W-1:0] WRITABLE_MASK = 32'h0000_FFF7;

    typedef struct packed {
        logic [15:0]      rsvd_hi;
        logic             pull_from_reg;
        logic             pu;
        logic             pd;
        logic [DRV_W-1:0] drive;
        logic             lp_sel;
        logic             lp_data;
        logic             lp_oe_n;
        logic             edge_off;
        logic             fall_en;
        logic             rise_en;
        logic             rsvd3;
        logic [SEL_W-1:0] func;
    } cfg_t;

    typedef struct packed {
        logic out;
        logic oe;
        logic pu;
        logic pd;
    } pad_ctl_t;

    function automatic cfg_t sanitize(input logic [REG_W-1:0] w);
        return cfg_t'(w & WRITABLE_MASK);
    endfunction
endpackage

// File: rtl/mfpad_cfg_reg.sv
module mfpad_cfg_reg
    import mfpad_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output cfg_t             cfg
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (we)
            cfg <= sanitize(wdata);
    end
endmodule

// File: rtl/mfpad_fn_mux.sv
module mfpad_fn_mux
    import mfpad_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    output pad_ctl_t            chosen
);
    logic [NUM_FUNC-1:0] hit;

    for (genvar i = 0; i < NUM_FUNC; i++) begin : g_dec
        assign hit[i] = (sel == SEL_W'(i));
    end

    always_comb begin
        chosen.out = |(fn_out & hit);
        chosen.oe  = |(fn_oe  & hit);
        chosen.pu  = |(fn_pu  & hit);
        chosen.pd  = |(fn_pd  & hit);
    end
endmodule

// File: rtl/mfpad_edge_det.sv
module mfpad_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic hold_off,
    input  logic clr,
    output logic flag
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;
    logic                   rose;
    logic                   fell;

    always_ff @(posedge clk) begin
        if (rst)
            sync_q <= '0;
        else
            sync_q <= {sync_q[LAST-1:0], pad_in};
    end

    assign level = sync_q[LAST];

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b0;
        else
            prev_q <= level;
    end

    assign rose = level & ~prev_q;
    assign fell = ~level & prev_q;

    always_ff @(posedge clk) begin
        if (rst || clr)
            flag <= 1'b0;
        else if (!hold_off && ((rose && rise_en) || (fell && fall_en)))
            flag <= 1'b1;
    end
endmodule

// File: rtl/mfpad_ctrl.sv
module mfpad_ctrl
    import mfpad_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [NUM_FUNC-1:0] fn_out,
    input  logic [NUM_FUNC-1:0] fn_oe,
    input  logic [NUM_FUNC-1:0] fn_pu,
    input  logic [NUM_FUNC-1:0] fn_pd,
    input  logic                low_power,
    input  logic                wake_en,
    input  logic                pad_in,
    output logic                pad_out,
    output logic                pad_oe,
    output logic                pad_pu,
    output logic                pad_pd,
    output logic [DRV_W-1:0]    pad_drive,
    output logic                edge_flag,
    output logic                wake_req
);
    cfg_t     cfg;
    pad_ctl_t chosen;
    logic     override;
    logic     clr_wr;

    mfpad_cfg_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .wdata (reg_wdata),
        .cfg   (cfg)
    );

    mfpad_fn_mux u_mux (
        .sel    (cfg.func),
        .fn_out (fn_out),
        .fn_oe  (fn_oe),
        .fn_pu  (fn_pu),
        .fn_pd  (fn_pd),
        .chosen (chosen)
    );

    assign clr_wr = reg_we & reg_wdata[6];

    mfpad_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pad_in   (pad_in),
        .rise_en  (cfg.rise_en),
        .fall_en  (cfg.fall_en),
        .hold_off (cfg.edge_off),
        .clr      (clr_wr),
        .flag     (edge_flag)
    );

    assign override  = low_power & cfg.lp_sel;
    assign reg_rdata = cfg;

    always_comb begin
        if (override) begin
            pad_out = cfg.lp_data;
            pad_oe  = ~cfg.lp_oe_n;
        end else begin
            pad_out = chosen.out;
            pad_oe  = chosen.oe;
        end
        if (cfg.pull_from_reg) begin
            pad_pu = cfg.pu;
            pad_pd = cfg.pd;
        end else begin
            pad_pu = chosen.pu;
            pad_pd = chosen.pd;
        end
    end

    assign pad_drive = cfg.drive;
    assign wake_req  = edge_flag & wake_en;
endmodule

// File: rtl/mfpad_ctrl_checker.sv
module mfpad_ctrl_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic        low_power,
    input logic        wake_en,
    input logic        pad_out,
    input logic        pad_oe,
    input logic        pad_pu,
    input logic        pad_pd,
    input logic [2:0]  pad_drive,
    input logic        edge_flag,
    input logic        wake_req
);
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[31:16] == 16'h0) && !reg_rdata[3]);

    a_r3_override: assert property (@(posedge clk) disable iff (rst)
        (low_power && reg_rdata[9]) |-> (pad_oe == !reg_rdata[7]) && (pad_out == reg_rdata[8]));

    a_r5_pull_reg: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[15] |-> (pad_pu == reg_rdata[14]) && (pad_pd == reg_rdata[13]));

    a_r6_drive: assert property (@(posedge clk) disable iff (rst)
        pad_drive == reg_rdata[12:10]);

    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (edge_flag && !(reg_we && reg_wdata[6])) |=> edge_flag);

    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_wdata[6]) |=> !edge_flag);

    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[6] && !edge_flag) |=> !edge_flag);

    a_r10_wake: assert property (@(posedge clk) disable iff (rst)
        wake_req == (edge_flag && wake_en));
endmodule

bind mfpad_ctrl mfpad_ctrl_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .low_power (low_power),
    .wake_en   (wake_en),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .pad_pd    (pad_pd),
    .pad_drive (pad_drive),
    .edge_flag (edge_flag),
    .wake_req  (wake_req)
);

// File: tb/tb_mfpad_ctrl.sv
module tb_mfpad_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [7:0]  fn_out = '0, fn_oe = '0, fn_pu = '0, fn_pd = '0;
    logic        low_power = 1'b0, wake_en = 1'b0, pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_pu, pad_pd, edge_flag, wake_req;
    logic [2:0]  pad_drive;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model_reg = '0;

    always #2.5 clk = ~clk;

    mfpad_ctrl dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fn_out(fn_out), .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd),
        .low_power(low_power), .wake_en(wake_en), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .pad_drive(pad_drive), .edge_flag(edge_flag), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_drive_pair(input logic [31:0] r, input logic lp,
                                                  input logic [7:0] fo, input logic [7:0] fe);
        if (lp && r[9]) return {r[8], ~r[7]};
        return {fo[r[2:0]], fe[r[2:0]]};
    endfunction

    function automatic logic [1:0] exp_pull_pair(input logic [31:0] r,
                                                 input logic [7:0] pu, input logic [7:0] pd);
        if (r[15]) return {r[14], r[13]};
        return {pu[r[2:0]], pd[r[2:0]]};
    endfunction

    task automatic write_reg(input logic [31:0] w);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_we = 1'b0;
        model_reg = w & 32'h0000_FFF7;
    endtask

    task automatic check_static(input string tag);
        #1;
        check({tag, " R1"}, reg_rdata, model_reg);
        check({tag, " R2/R3/R4"}, {30'h0, pad_out, pad_oe},
              {30'h0, exp_drive_pair(model_reg, low_power, fn_out, fn_oe)});
        check({tag, " R5"}, {30'h0, pad_pu, pad_pd}, {30'h0, exp_pull_pair(model_reg, fn_pu, fn_pd)});
        check({tag, " R6"}, {29'h0, pad_drive}, {29'h0, model_reg[12:10]});
    endtask

    task automatic set_pad(input logic v);
        @(negedge clk);
        pad_in = v;
    endtask

    initial begin
        #200000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset value", reg_rdata, 32'h0);
        check("R7 reset flag", {31'h0, edge_flag}, 32'h0);
        check("R10 reset wake", {31'h0, wake_req}, 32'h0);

        // Directed: reserved bits all ones.
        write_reg(32'hFFFF_0008);
        check("R1 reserved only", reg_rdata, 32'h0);
        write_reg(32'hFFFF_FFFF);
        check("R1 all ones", reg_rdata, 32'h0000_FFF7);

        // Directed: override vs no override with every function driving 1.
        fn_out = 8'hFF; fn_oe = 8'hFF;
        write_reg(32'h0000_0280);  // lp_sel=1, lp_oe_n=1, lp_data=0
        low_power = 1'b1;
        check_static("override on");
        check("R3 oe off under override", {31'h0, pad_oe}, 32'h0);
        low_power = 1'b0;
        check_static("override off");
        check("R4 function drives", {30'h0, pad_out, pad_oe}, 32'h3);

        // Random sweep.
        for (int i = 0; i < 300; i++) begin
            fn_out = 8'($urandom); fn_oe = 8'($urandom);
            fn_pu = 8'($urandom); fn_pd = 8'($urandom);
            low_power = 1'($urandom);
            write_reg($urandom);
            check_static("random");
        end
        low_power = 1'b0;

        // Edge detection: rising enabled.
        write_reg(32'h0000_0040);     // clear
        write_reg(32'h0000_0010);     // rise only
        check("R9 cleared after write", {31'h0, edge_flag}, 32'h0);
        set_pad(1'b1);
        @(negedge clk); @(negedge clk); #1;
        check("R7 not yet after two edges", {31'h0, edge_flag}, 32'h0);
        @(negedge clk); #1;
        check("R7 rise seen at third edge", {31'h0, edge_flag}, 32'h1);
        check("R10 no wake without enable", {31'h0, wake_req}, 32'h0);
        wake_en = 1'b1; #1;
        check("R10 wake with enable", {31'h0, wake_req}, 32'h1);
        set_pad(1'b0);
        repeat (4) @(negedge clk); #1;
        check("R7 flag sticky", {31'h0, edge_flag}, 32'h1);

        // Falling edge with only rise enabled: no flag.
        write_reg(32'h0000_0040);
        write_reg(32'h0000_0010);
        set_pad(1'b1);
        repeat (4) @(negedge clk);
        write_reg(32'h0000_0040);
        write_reg(32'h0000_0010);
        set_pad(1'b0);
        repeat (5) @(negedge clk); #1;
        check("R8 fall ignored when disabled", {31'h0, edge_flag}, 32'h0);
        check("R10 wake low", {31'h0, wake_req}, 32'h0);

        // Falling enabled.
        write_reg(32'h0000_0020);
        set_pad(1'b1);
        repeat (5) @(negedge clk); #1;
        check("R8 rise ignored with fall only", {31'h0, edge_flag}, 32'h0);
        set_pad(1'b0);
        repeat (3) @(negedge clk); #1;
        check("R7 fall seen", {31'h0, edge_flag}, 32'h1);

        // Clear bit held: both polarities enabled, no detection.
        write_reg(32'h0000_0070);
        check("R9 clear write", {31'h0, edge_flag}, 32'h0);
        set_pad(1'b1);
        repeat (5) @(negedge clk);
        set_pad(1'b0);
        repeat (5) @(negedge clk); #1;
        check("R9 detection suppressed", {31'h0, edge_flag}, 32'h0);
        write_reg(32'h0000_0030);
        set_pad(1'b1);
        repeat (3) @(negedge clk); #1;
        check("R9 detection resumes", {31'h0, edge_flag}, 32'h1);
        wake_en = 1'b0; #1;
        check("R10 wake drops", {31'h0, wake_req}, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule